// File: doc/BRIEF.md
# Shared Display/Auxiliary RAM Address Map and Space Filler

This block sits between a microcontroller's external-data port and a single on-chip RAM that is split into a dedicated auxiliary region and a display region. Each CPU request is decoded into a physical RAM address. The display region has two CPU windows, one for teletext mode and one for caption mode. Both windows land on the same physical storage, so a byte written through one window can be read back through the other.

When power-on reset ends, and again whenever idle mode is left through a reset, the block walks the whole display region. It writes the space code into one location per clock, and the CPU is held off until the walk is complete. Leaving idle mode through an interrupt does not disturb the display data. The auxiliary region is never written by the block.

Top module: `shared_ram_map`

## Requirements
- R1: CPU addresses 0000h to 07FFh reach physical RAM address equal to the CPU address in either mode (`modeCaption` 0 = teletext, 1 = caption).
- R2: With `modeCaption`=0, CPU addresses 2000h to 47FFh reach physical address 2048 + (address - 2000h).
- R3: With `modeCaption`=1, CPU addresses 8000h to 86FFh reach physical address 2048 + (address - 8000h), so that 8000h+n and 2000h+n share one location.
- R4: Any address outside the decoded windows for the current mode makes the response carry `cpuErr`=1 and data FFh, and no RAM cycle is issued for that request.
- R5: After power-on reset, `busy` is high while the block writes 20h to physical addresses 2048 to 12287. It writes one address per clock in ascending order, then drops `busy`.
- R6: A one-cycle `wakeValid` with `wakeByReset`=1 restarts the fill from physical address 2048 and leaves auxiliary contents intact.
- R7: A `wakeValid` with `wakeByReset`=0 neither raises `busy` nor alters any display contents.
- R8: A request raised while `busy` is high receives no acknowledge until the fill has finished. It is served afterwards with post-fill data.
- R9: The mode is taken when the request is captured; a change of `modeCaption` after capture does not affect that access.
- R10: A request in idle is acknowledged by a one-cycle `cpuAck` on the second rising edge after `cpuReq` is first seen high. Reads return the RAM word, which the RAM delivers one cycle after its enable. Successful writes return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| wakeValid | input | 1 | One-cycle pulse: idle mode is ending |
| wakeByReset | input | 1 | 1 = idle left by reset, 0 = left by interrupt |
| modeCaption | input | 1 | 0 = teletext window, 1 = caption window |
| cpuReq | input | 1 | CPU access request, held until `cpuAck` |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 16 | CPU external-data address |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | Response data, valid with `cpuAck` |
| cpuAck | output | 1 | Response strobe |
| cpuErr | output | 1 | Address miss, valid with `cpuAck` |
| busy | output | 1 | Space fill in progress |
| ramEn | output | 1 | RAM cycle enable |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | 14 | Physical RAM address |
| ramWdata | output | 8 | RAM write data |
| ramRdata | input | 8 | RAM read data, one cycle after enable |

## Verification
A corrupted offset or a wrongly latched mode shows at the RAM port in the cycle the access is issued. It also reaches `cpuRdata` two edges after the request, because reading through the other window returns a different byte. A fill counter that skips a step, starts off base or stops early changes the count or order of fill writes on the RAM port within the fill itself. It also leaves a non-space byte readable right after `busy` falls. A state machine stuck in the wrong state shows at once as a missing acknowledge or as `busy` that never drops.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {ST_FILL, ST_IDLE, ST_ACC, ST_RSP} mapState_t;

  typedef struct packed {
    logic fillClr;
    logic fill;
    logic capture;
    logic access;
    logic respond;
  } mapStrobe_t;

  localparam logic [7:0] SPACE_CODE = 8'h20;
  localparam logic [7:0] MISS_DATA  = 8'hFF;
endpackage

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       wakeValid,
  input  logic       wakeByReset,
  input  logic       fillLast,
  output mapStrobe_t strb,
  output logic       busy,
  output logic       cpuAck
);
  mapState_t state, stateNext;
  logic wakeRst;

  assign wakeRst = wakeValid && wakeByReset;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_FILL: if (fillLast) stateNext = ST_IDLE;
      ST_IDLE: if (cpuReq) stateNext = ST_ACC;
      ST_ACC:  stateNext = ST_RSP;
      ST_RSP:  stateNext = ST_IDLE;
      default: stateNext = ST_FILL;
    endcase
    if (wakeRst) stateNext = ST_FILL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FILL;
    else       state <= stateNext;
  end

  always_comb begin
    strb.fillClr = wakeRst;
    strb.fill    = (state == ST_FILL);
    strb.capture = (state == ST_IDLE) && cpuReq && !wakeRst;
    strb.access  = (state == ST_ACC) && !wakeRst;
    strb.respond = (state == ST_RSP) && !wakeRst;
  end

  assign busy   = (state == ST_FILL);
  assign cpuAck = strb.respond;

  // R10: acknowledge is a single-cycle pulse
  p_ack_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |=> !cpuAck);
  // R10: acknowledge follows an issued access
  p_ack_after_access_r10: assert property (@(posedge clk) disable iff (!rstN)
    cpuAck |-> $past(strb.access));
  // R6: wake by reset starts a fill
  p_wake_reset_fills_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeRst |=> busy);
  // R7: wake by interrupt never starts a fill
  p_wake_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeValid && !wakeByReset && !busy) |=> !busy);
  // R5: fill runs until its last word
  p_fill_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !fillLast) |=> busy);
endmodule

// File: rtl/srm_datapath.sv
module srm_datapath
  import srm_pkg::*;
#(
  parameter int AUX_WORDS  = 2048,
  parameter int DISP_WORDS = 10240,
  parameter int CC_WORDS   = 1792,
  parameter int TXT_BASE   = 'h2000,
  parameter int CC_BASE    = 'h8000,
  parameter int PHYS_AW    = $clog2(AUX_WORDS + DISP_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  mapStrobe_t         strb,
  input  logic               modeCaption,
  input  logic               cpuWe,
  input  logic [15:0]        cpuAddr,
  input  logic [7:0]         cpuWdata,
  output logic               fillLast,
  output logic [7:0]         cpuRdata,
  output logic               cpuErr,
  output logic               ramEn,
  output logic               ramWe,
  output logic [PHYS_AW-1:0] ramAddr,
  output logic [7:0]         ramWdata,
  input  logic [7:0]         ramRdata
);
  localparam int DISP_AW = $clog2(DISP_WORDS);
  localparam logic [PHYS_AW-1:0] DISP_PHYS_BASE = PHYS_AW'(AUX_WORDS);

  logic [15:0]        reqAddr;
  logic               reqWe, reqMode, errQ;
  logic [7:0]         reqWdata;
  logic [DISP_AW-1:0] fillCnt;

  logic               auxHit, txtHit, ccHit, hit;
  logic [15:0]        txtOff, ccOff, dispOff;
  logic [PHYS_AW-1:0] physAddr;

  assign fillLast = (fillCnt == DISP_AW'(DISP_WORDS - 1));

  // window decode on the captured request
  always_comb begin
    txtOff  = reqAddr - 16'(TXT_BASE);
    ccOff   = reqAddr - 16'(CC_BASE);
    auxHit  = reqAddr < 16'(AUX_WORDS);
    txtHit  = !reqMode && (reqAddr >= 16'(TXT_BASE)) && (txtOff < 16'(DISP_WORDS));
    ccHit   = reqMode && (reqAddr >= 16'(CC_BASE)) && (ccOff < 16'(CC_WORDS));
    hit     = auxHit || txtHit || ccHit;
    dispOff = reqMode ? ccOff : txtOff;
    physAddr = auxHit ? PHYS_AW'(reqAddr) : DISP_PHYS_BASE + PHYS_AW'(dispOff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWe    <= 1'b0;
      reqMode  <= 1'b0;
      reqWdata <= '0;
      errQ     <= 1'b0;
      fillCnt  <= '0;
    end else begin
      if (strb.capture) begin
        reqAddr  <= cpuAddr;
        reqWe    <= cpuWe;
        reqMode  <= modeCaption;
        reqWdata <= cpuWdata;
      end
      if (strb.access) errQ <= !hit;
      if (strb.fillClr)   fillCnt <= '0;
      else if (strb.fill) fillCnt <= fillLast ? '0 : fillCnt + 1'b1;
    end
  end

  always_comb begin
    ramEn    = strb.fill || (strb.access && hit);
    ramWe    = strb.fill || reqWe;
    ramAddr  = strb.fill ? DISP_PHYS_BASE + PHYS_AW'(fillCnt) : physAddr;
    ramWdata = strb.fill ? SPACE_CODE : reqWdata;
  end

  always_comb begin
    cpuErr   = strb.respond && errQ;
    cpuRdata = 8'h00;
    if (strb.respond) begin
      if (errQ)        cpuRdata = MISS_DATA;
      else if (!reqWe) cpuRdata = ramRdata;
    end
  end

  // R4: a missed request left the RAM idle in its access cycle
  p_miss_no_ram_r4: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> $past(!ramEn));
  // R5: fill addresses step by one
  p_fill_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fill && !fillLast && !strb.fillClr) |=> (ramAddr == $past(ramAddr) + 1'b1));
  // R5: fill stays inside the display region
  p_fill_in_disp_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.fill |-> (ramAddr >= DISP_PHYS_BASE));
  // R9: captured mode is steady while the response is given
  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.respond |-> $stable(reqMode));
endmodule

// File: rtl/shared_ram_map.sv
module shared_ram_map
  import srm_pkg::*;
#(
  parameter int AUX_WORDS  = 2048,
  parameter int DISP_WORDS = 10240,
  parameter int CC_WORDS   = 1792,
  parameter int TXT_BASE   = 'h2000,
  parameter int CC_BASE    = 'h8000,
  parameter int PHYS_AW    = $clog2(AUX_WORDS + DISP_WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wakeValid,
  input  logic               wakeByReset,
  input  logic               modeCaption,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [15:0]        cpuAddr,
  input  logic [7:0]         cpuWdata,
  output logic [7:0]         cpuRdata,
  output logic               cpuAck,
  output logic               cpuErr,
  output logic               busy,
  output logic               ramEn,
  output logic               ramWe,
  output logic [PHYS_AW-1:0] ramAddr,
  output logic [7:0]         ramWdata,
  input  logic [7:0]         ramRdata
);
  mapStrobe_t strb;
  logic       fillLast;

  srm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .wakeValid(wakeValid),
    .wakeByReset(wakeByReset), .fillLast(fillLast), .strb(strb),
    .busy(busy), .cpuAck(cpuAck)
  );

  srm_datapath #(
    .AUX_WORDS(AUX_WORDS), .DISP_WORDS(DISP_WORDS), .CC_WORDS(CC_WORDS),
    .TXT_BASE(TXT_BASE), .CC_BASE(CC_BASE), .PHYS_AW(PHYS_AW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .modeCaption(modeCaption),
    .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .fillLast(fillLast), .cpuRdata(cpuRdata), .cpuErr(cpuErr),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr), .ramWdata(ramWdata),
    .ramRdata(ramRdata)
  );
endmodule

// File: tb/shared_ram_map_bench.sv
`timescale 1ns/1ps
module shared_ram_map_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic wakeValid = 1'b0, wakeByReset = 1'b0, modeCaption = 1'b0;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata, ramWdata;
  logic [7:0]  ramRdata = '0;
  logic cpuAck, cpuErr, busy, ramEn, ramWe;
  logic [13:0] ramAddr;

  always #2.5 clk = ~clk;

  shared_ram_map u_shared_ram_map (
    .clk(clk), .rstN(rstN), .wakeValid(wakeValid), .wakeByReset(wakeByReset),
    .modeCaption(modeCaption), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuAck(cpuAck), .cpuErr(cpuErr),
    .busy(busy), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // synchronous RAM model: sample at negedge, act at posedge
  logic [7:0] mem [int];
  logic pEn, pWe; logic [13:0] pAddr; logic [7:0] pWd;
  int ramOps = 0, fillWrites = 0, fillSeqErr = 0, fillNext = 2048;
  int checks = 0, fails = 0;

  always @(negedge clk) begin
    pEn = ramEn; pWe = ramWe; pAddr = ramAddr; pWd = ramWdata;
    if (rstN && ramEn && !busy) ramOps++;
    if (rstN && ramEn && busy) begin
      if (int'(ramAddr) != fillNext || !ramWe || ramWdata != 8'h20) fillSeqErr++;
      fillNext = int'(ramAddr) + 1;
      fillWrites++;
    end
  end

  always @(posedge clk) begin
    if (pEn) begin
      if (pWe) mem[int'(pAddr)] = pWd;
      else     ramRdata <= mem.exists(int'(pAddr)) ? mem[int'(pAddr)] : 8'h00;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doAccess(input logic we, input logic mode, input logic [15:0] addr,
                          input logic [7:0] wd, input bit flip, input int limit,
                          output logic [7:0] rd, output logic err,
                          output int lat, output int ops);
    int opsStart;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; modeCaption = mode; cpuAddr = addr; cpuWdata = wd;
    opsStart = ramOps; lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      if (flip && lat == 1) modeCaption = !mode;
      if (cpuAck || lat > limit) break;
    end
    rd = cpuRdata; err = cpuErr; cpuReq = 1'b0;
    ops = ramOps - opsStart;
  endtask

  task automatic waitFill();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
  endtask

  task automatic pulseWake(input logic byReset);
    @(negedge clk); wakeValid = 1'b1; wakeByReset = byReset;
    @(negedge clk); wakeValid = 1'b0; wakeByReset = 1'b0;
  endtask

  typedef struct packed {
    logic we; logic mode; logic [15:0] addr; logic [7:0] wd;
    logic [7:0] exp; logic err; logic ops; logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0000, 8'hA5, 8'h00, 1'b0, 1'b1, 4'd1},  // R1 aux write
    '{1'b0, 1'b0, 16'h0000, 8'h00, 8'hA5, 1'b0, 1'b1, 4'd1},  // R1 aux read
    '{1'b1, 1'b0, 16'h07FF, 8'h3C, 8'h00, 1'b0, 1'b1, 4'd1},  // R1 top of aux
    '{1'b0, 1'b1, 16'h07FF, 8'h00, 8'h3C, 1'b0, 1'b1, 4'd1},  // R1 aux in caption mode
    '{1'b0, 1'b0, 16'h2000, 8'h00, 8'h20, 1'b0, 1'b1, 4'd5},  // R5 first filled word
    '{1'b0, 1'b0, 16'h47FF, 8'h00, 8'h20, 1'b0, 1'b1, 4'd2},  // R2 last teletext word
    '{1'b1, 1'b0, 16'h2005, 8'h41, 8'h00, 1'b0, 1'b1, 4'd2},  // R2 teletext write
    '{1'b0, 1'b1, 16'h8005, 8'h00, 8'h41, 1'b0, 1'b1, 4'd3},  // R3 alias read
    '{1'b1, 1'b1, 16'h86FF, 8'h77, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 top of caption
    '{1'b0, 1'b0, 16'h26FF, 8'h00, 8'h77, 1'b0, 1'b1, 4'd3},  // R3 seen via teletext
    '{1'b0, 1'b0, 16'h0800, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 gap above aux
    '{1'b0, 1'b0, 16'h4800, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 past teletext
    '{1'b0, 1'b1, 16'h8700, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 past caption
    '{1'b0, 1'b1, 16'h2000, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 wrong mode
    '{1'b0, 1'b0, 16'h8000, 8'h00, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 wrong mode
    '{1'b1, 1'b0, 16'h4800, 8'h99, 8'hFF, 1'b1, 1'b0, 4'd4},  // R4 write suppressed
    '{1'b1, 1'b1, 16'h8000, 8'h12, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 caption base
    '{1'b0, 1'b0, 16'h2000, 8'h00, 8'h12, 1'b0, 1'b1, 4'd3}   // R3 teletext base
  };

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] rd; logic err; int lat, ops;
    repeat (3) @(negedge clk);
    check(busy === 1'b1 && cpuAck === 1'b0, "R5", "reset state busy/ack",
          {busy, cpuAck}, 2'b10);
    rstN = 1'b1;
    waitFill();
    check(fillWrites == 10240, "R5", "power-up fill count", fillWrites, 10240);
    check(fillSeqErr == 0, "R5", "fill order/data", fillSeqErr, 0);

    for (int i = 0; i < NV; i++) begin
      doAccess(VECS[i].we, VECS[i].mode, VECS[i].addr, VECS[i].wd, 1'b0, 50,
               rd, err, lat, ops);
      check(rd == VECS[i].exp && err == VECS[i].err && ops == int'(VECS[i].ops),
            $sformatf("R%0d", VECS[i].req), $sformatf("vector %0d data/err/ops", i),
            {rd, err, 8'(ops)}, {VECS[i].exp, VECS[i].err, 8'(VECS[i].ops)});
      check(lat == 2, "R10", $sformatf("vector %0d latency", i), lat, 2);
    end

    // R9: mode flips after capture; teletext view of 2005h must be used
    doAccess(1'b0, 1'b0, 16'h2005, 8'h00, 1'b1, 50, rd, err, lat, ops);
    check(rd == 8'h41 && !err, "R9", "mode flip after capture", rd, 8'h41);

    // R7: wake by interrupt keeps display and stays ready
    doAccess(1'b1, 1'b0, 16'h2010, 8'h55, 1'b0, 50, rd, err, lat, ops);
    doAccess(1'b1, 1'b0, 16'h0010, 8'h66, 1'b0, 50, rd, err, lat, ops);
    pulseWake(1'b0);
    check(busy == 1'b0, "R7", "busy after irq wake", busy, 0);
    doAccess(1'b0, 1'b1, 16'h8010, 8'h00, 1'b0, 50, rd, err, lat, ops);
    check(rd == 8'h55 && lat == 2, "R7", "display kept after irq wake", rd, 8'h55);

    // R6 / R8: wake by reset refills; request raised during fill waits
    fillNext = 2048; fillWrites = 0; fillSeqErr = 0;
    pulseWake(1'b1);
    check(busy == 1'b1, "R6", "busy after reset wake", busy, 1);
    doAccess(1'b0, 1'b0, 16'h2010, 8'h00, 1'b0, 20000, rd, err, lat, ops);
    check(lat > 10000, "R8", "held off while busy", lat, 10000);
    check(rd == 8'h20 && !err, "R8", "served after fill", rd, 8'h20);
    check(fillWrites == 10240 && fillSeqErr == 0, "R6", "refill count/order",
          fillWrites, 10240);
    doAccess(1'b0, 1'b0, 16'h0010, 8'h00, 1'b0, 50, rd, err, lat, ops);
    check(rd == 8'h66, "R6", "aux kept across reset wake", rd, 8'h66);
    doAccess(1'b0, 1'b1, 16'h86FF, 8'h00, 1'b0, 50, rd, err, lat, ops);
    check(rd == 8'h20, "R6", "caption view refilled", rd, 8'h20);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule